// File: doc/BRIEF.md
# Vector Divide Operand Range Checker

This block screens the operands of a two-lane double-precision divide before a fast iterative software divide sequence runs. Each lane holds a dividend and a divisor in IEEE-754 binary64 form. For each lane the block classifies both operands as NaN, infinity, zero or denormal. It then applies window tests on the unbiased exponents of the divisor and of the dividend, and on their difference. The outcome is two flags. The first warns that the fast sequence may overflow, underflow or lose precision, so a slow fix-up path must be taken. The second marks the operand classes that the fast sequence cannot handle at all. Neither flag performs or needs a division.

The lane flags are OR-combined across lanes and packed into a 4-bit condition word with a constant one on top. Software issues an operand pair together with a valid strobe. One cycle later it receives the condition word with an output strobe. If the vector unit is disabled, the request is refused instead: a fault pulse appears in place of the result strobe, and the condition word stays clear.

Control is a three-state machine. IDLE means no result is presented. RESULT presents a condition word for one cycle. FAULT presents the unavailable pulse for one cycle. The transitions are:
- to_result: in_valid with unit_en high.
- to_fault: in_valid with unit_en low.
- to_idle: no in_valid.

These transitions are taken from every state, so back-to-back requests are accepted on consecutive cycles.

Top module: `vdiv_range_screen`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, out_valid and out_fault are 0 and cond is 4'b0000.
- R2: A cycle with in_valid=1 and unit_en=1 makes out_valid 1 on the next cycle, for exactly that one cycle. In that cycle cond = {1'b1, fg, fe, 1'b0}: bit 3 is constant 1, bit 2 is fg, bit 1 is fe, bit 0 is 0.
- R3: A cycle with in_valid=1 and unit_en=0 makes out_fault 1 on the next cycle, with out_valid 0 and cond 4'b0000.
- R4: A cycle with in_valid=0 gives out_valid=0, out_fault=0 and cond=4'b0000 on the next cycle, whatever the operand inputs hold.
- R5: Lane 0 is bits [127:64] and lane 1 is bits [63:0] of each vector. fe and fg are each the OR of the per-lane results, so a condition in either lane alone sets the flag.
- R6: fe is set for a lane if either operand is NaN or infinity, or if the divisor is zero (either sign). NaN is exponent 2047 with a nonzero fraction. Infinity is exponent 2047 with a zero fraction.
- R7: fe is set for a lane if the divisor's biased exponent field (bits 62:52) is 1 or less, or is 2044 or more. These limits are unbiased -1022 and +1021.
- R8: For a nonzero dividend, fe is set if the unbiased difference (dividend minus divisor) is at least 1023 or at most -1021, or if the dividend's unbiased exponent is -970 or less. For a zero dividend these three tests are skipped.
- R9: fg is set for a lane if either operand is infinity, or if the divisor is zero or denormal. Denormal is exponent 0 with a nonzero fraction.
- R10: A NaN operand, with no other fg cause, leaves fg at 0 while it sets fe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Vector unit enabled; 0 turns requests into faults |
| in_valid | input | 1 | Operand pair valid this cycle |
| dividend_vec | input | 128 | Two binary64 dividends, lane 0 in [127:64] |
| divisor_vec | input | 128 | Two binary64 divisors, lane 0 in [127:64] |
| out_valid | output | 1 | Condition word valid (one cycle) |
| out_fault | output | 1 | Vector-unit-unavailable pulse (one cycle) |
| cond | output | 4 | Condition word {1, fg, fe, 0}; 0 when out_valid is low |

## Verification
The directed patterns place exponents on each side of every window edge: divisor fields 1/2 and 2043/2044, dividend fields 53/54, and differences of 1022/1023 and -1020/-1021. These separate an off-by-one or sign error in any single threshold. Zero, negative-zero, denormal, infinity and NaN operands are put into one lane at a time. This shows which class drives which flag and that each lane reaches the OR. A zero dividend with an otherwise out-of-window difference shows the exemption in R8. Random operands, weighted toward those boundary fields and the special classes, are mixed with disabled and idle cycles. They are compared against a bench model of the rules, which catches interactions the directed cases miss.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } vdiv_state_e;

    typedef struct packed {
        logic nan;
        logic inf;
        logic zero;
        logic denorm;
    } fp_class_t;

endpackage

// File: rtl/vdiv_lane_screen.sv
module vdiv_lane_screen
    import vdiv_pkg::*;
#(
    parameter int LANE_W = 64,
    parameter int EXP_W  = 11,
    parameter int BIAS   = 1023
) (
    input  logic [LANE_W-1:0] dividend,
    input  logic [LANE_W-1:0] divisor,
    output logic              lane_fe,
    output logic              lane_fg
);
    localparam int FRAC_W = LANE_W - 1 - EXP_W;
    localparam int SE_W   = EXP_W + 2;

    // Window limits on unbiased exponents, derived from the format
    localparam logic signed [SE_W-1:0] DVSR_LO = SE_W'(-(BIAS - 1));
    localparam logic signed [SE_W-1:0] DVSR_HI = SE_W'(BIAS - 2);
    localparam logic signed [SE_W-1:0] DIFF_HI = SE_W'(BIAS);
    localparam logic signed [SE_W-1:0] DIFF_LO = SE_W'(-(BIAS - 2));
    localparam logic signed [SE_W-1:0] DVND_LO = SE_W'(-(BIAS - FRAC_W - 1));
    localparam logic signed [SE_W-1:0] BIAS_S  = SE_W'(BIAS);

    function automatic fp_class_t classify(input logic [EXP_W-1:0] e,
                                           input logic [FRAC_W-1:0] f);
        fp_class_t c;
        c.nan    = (&e) && (|f);
        c.inf    = (&e) && !(|f);
        c.zero   = !(|e) && !(|f);
        c.denorm = !(|e) && (|f);
        return c;
    endfunction

    logic [EXP_W-1:0]         exp_a, exp_b;
    logic [FRAC_W-1:0]        frac_a, frac_b;
    fp_class_t                cls_a, cls_b;
    logic signed [SE_W-1:0]   ue_a, ue_b, ue_diff;
    logic                     special_fe, window_fe, ratio_fe;
    logic                     unused_signs;

    assign exp_a  = dividend[LANE_W-2 -: EXP_W];
    assign exp_b  = divisor[LANE_W-2 -: EXP_W];
    assign frac_a = dividend[FRAC_W-1:0];
    assign frac_b = divisor[FRAC_W-1:0];
    assign unused_signs = dividend[LANE_W-1] ^ divisor[LANE_W-1];

    always_comb begin
        cls_a   = classify(exp_a, frac_a);
        cls_b   = classify(exp_b, frac_b);
        ue_a    = $signed({{(SE_W-EXP_W){1'b0}}, exp_a}) - BIAS_S;
        ue_b    = $signed({{(SE_W-EXP_W){1'b0}}, exp_b}) - BIAS_S;
        ue_diff = ue_a - ue_b;

        special_fe = cls_a.nan | cls_a.inf | cls_b.nan | cls_b.inf | cls_b.zero;
        window_fe  = (ue_b <= DVSR_LO) | (ue_b >= DVSR_HI);
        ratio_fe   = !cls_a.zero &
                     ((ue_diff >= DIFF_HI) | (ue_diff <= DIFF_LO) | (ue_a <= DVND_LO));

        lane_fe = special_fe | window_fe | ratio_fe;
        lane_fg = cls_a.inf | cls_b.inf | cls_b.zero | cls_b.denorm;
    end

endmodule

// File: rtl/vdiv_flag_merge.sv
module vdiv_flag_merge #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] fe_vec,
    input  logic [LANES-1:0] fg_vec,
    output logic             any_fe,
    output logic             any_fg
);
    logic [LANES:0] fe_chain, fg_chain;

    assign fe_chain[0] = 1'b0;
    assign fg_chain[0] = 1'b0;

    for (genvar i = 0; i < LANES; i++) begin : g_or
        assign fe_chain[i+1] = fe_chain[i] | fe_vec[i];
        assign fg_chain[i+1] = fg_chain[i] | fg_vec[i];
    end

    assign any_fe = fe_chain[LANES];
    assign any_fg = fg_chain[LANES];

endmodule

// File: rtl/vdiv_range_screen.sv
module vdiv_range_screen
    import vdiv_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 64,
    parameter int EXP_W  = 11,
    parameter int BIAS   = 1023,
    parameter int VEC_W  = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_en,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] dividend_vec,
    input  logic [VEC_W-1:0] divisor_vec,
    output logic             out_valid,
    output logic             out_fault,
    output logic [3:0]       cond
);
    logic [LANES-1:0] fe_vec, fg_vec;
    logic             any_fe, any_fg;
    vdiv_state_e      state_q, state_d;
    logic [3:0]       cond_q;

    // Lane 0 sits in the most significant half
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vdiv_lane_screen #(
            .LANE_W (LANE_W),
            .EXP_W  (EXP_W),
            .BIAS   (BIAS)
        ) u_lane (
            .dividend (dividend_vec[VEC_W-1-g*LANE_W -: LANE_W]),
            .divisor  (divisor_vec[VEC_W-1-g*LANE_W -: LANE_W]),
            .lane_fe  (fe_vec[g]),
            .lane_fg  (fg_vec[g])
        );
    end

    vdiv_flag_merge #(.LANES(LANES)) u_merge (
        .fe_vec (fe_vec),
        .fg_vec (fg_vec),
        .any_fe (any_fe),
        .any_fg (any_fg)
    );

    // Next-state logic: same transitions from every state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FAULT: begin
                if (in_valid && unit_en)       state_d = ST_RESULT;
                else if (in_valid && !unit_en) state_d = ST_FAULT;
                else                           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: condition word captured on entry to RESULT
    always_ff @(posedge clk) begin
        if (!rst_n)                    cond_q <= 4'b0000;
        else if (state_d == ST_RESULT) cond_q <= {1'b1, any_fg, any_fe, 1'b0};
        else                           cond_q <= 4'b0000;
    end

    assign out_valid = (state_q == ST_RESULT);
    assign out_fault = (state_q == ST_FAULT);
    assign cond      = cond_q;

    // R2
    valid_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && unit_en));

    // R3
    fault_follows_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> ($past(in_valid && !unit_en) && cond == 4'b0000));

    // R2
    cond_frame_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cond[3] && !cond[0]));

    // R4
    cond_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (cond == 4'b0000));

    // R9
    fg_implies_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cond[2]) |-> cond[1]);

endmodule

// File: tb/vdiv_range_screen_test.sv
`timescale 1ns/1ps
module vdiv_range_screen_test;

    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam int          WDOG = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         unit_en = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] dividend_vec = '0;
    logic [127:0] divisor_vec = '0;
    logic         out_valid, out_fault;
    logic [3:0]   cond;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vdiv_range_screen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .unit_en      (unit_en),
        .in_valid     (in_valid),
        .dividend_vec (dividend_vec),
        .divisor_vec  (divisor_vec),
        .out_valid    (out_valid),
        .out_fault    (out_fault),
        .cond         (cond)
    );

    function automatic logic [63:0] mk(input int e, input logic [51:0] f);
        return {1'b0, e[10:0], f};
    endfunction

    function automatic logic [1:0] lane_ref(input logic [63:0] a, input logic [63:0] b);
        int  ea, eb, d;
        bit  a_nan, a_inf, a_zero, b_nan, b_inf, b_zero, b_den, fe, fg;
        ea = int'(a[62:52]) - 1023;
        eb = int'(b[62:52]) - 1023;
        d  = ea - eb;
        a_nan  = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
        a_inf  = (a[62:52] == 11'h7FF) && (a[51:0] == 0);
        a_zero = (a[62:0] == 0);
        b_nan  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
        b_inf  = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
        b_zero = (b[62:0] == 0);
        b_den  = (b[62:52] == 0) && (b[51:0] != 0);
        fe = a_nan || a_inf || b_nan || b_inf || b_zero || (eb <= -1022) || (eb >= 1021) ||
             (!a_zero && ((d >= 1023) || (d <= -1021) || (ea <= -970)));
        fg = a_inf || b_inf || b_zero || b_den;
        return {fg, fe};
    endfunction

    function automatic logic [3:0] ref_cond(input logic [127:0] a, input logic [127:0] b);
        logic [1:0] l0, l1;
        l0 = lane_ref(a[127:64], b[127:64]);
        l1 = lane_ref(a[63:0], b[63:0]);
        return {1'b1, l0[1] | l1[1], l0[0] | l1[0], 1'b0};
    endfunction

    function automatic logic [63:0] rand_dbl();
        int          mode, e;
        logic [51:0] f;
        mode = int'($urandom_range(0, 7));
        case (mode)
            0: e = 0;
            1: e = 2047;
            2, 3: begin
                case ($urandom_range(0, 9))
                    0: e = 1;    1: e = 2;    2: e = 53;   3: e = 54;
                    4: e = 2043; 5: e = 2044; 6: e = 2045; 7: e = 2046;
                    8: e = 60;   default: e = 1081;
                endcase
            end
            default: e = int'($urandom_range(0, 2047));
        endcase
        f = {$urandom(), $urandom()};
        if ($urandom_range(0, 3) == 0) f = '0;
        return {1'($urandom_range(0, 1)), e[10:0], f};
    endfunction

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: {valid,fault,cond} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [127:0] a, input logic [127:0] b,
                         input logic en, input logic v, input string tag);
        logic [3:0] ec;
        @(negedge clk);
        dividend_vec = a;
        divisor_vec  = b;
        unit_en      = en;
        in_valid     = v;
        @(negedge clk);
        in_valid = 1'b0;
        ec = (v && en) ? ref_cond(a, b) : 4'b0000;
        check(tag, {out_valid, out_fault, cond}, {v && en, v && !en, ec});
    endtask

    task automatic pair(input logic [63:0] a0, input logic [63:0] b0, input string tag);
        apply({a0, ONE}, {b0, ONE}, 1'b1, 1'b1, tag);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 in reset", {out_valid, out_fault, cond}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {out_valid, out_fault, cond}, 6'b0);

        pair(ONE, ONE, "R2 benign");
        apply('0, '0, 1'b1, 1'b0, "R2 single-cycle valid");
        pair(ONE, mk(1, 52'h1), "R7 divisor field 1");
        pair(ONE, mk(2, 52'h0), "R7 divisor field 2");
        pair(ONE, mk(2044, 52'h0), "R7 divisor field 2044");
        pair(ONE, mk(2043, 52'h0), "R7 divisor field 2043");
        pair(mk(53, 52'h0), ONE, "R8 dividend -970");
        pair(mk(54, 52'h0), ONE, "R8 dividend -969");
        pair(mk(2046, 52'h0), ONE, "R8 diff 1023");
        pair(mk(2045, 52'h0), ONE, "R8 diff 1022");
        pair(mk(60, 52'h0), mk(1081, 52'h0), "R8 diff -1021");
        pair(mk(60, 52'h0), mk(1080, 52'h0), "R8 diff -1020");
        pair(64'h0, ONE, "R8 zero dividend exempt");
        pair(64'h8000_0000_0000_0000, mk(2043, 52'h0), "R8 neg zero dividend exempt");
        pair(ONE, 64'h0, "R6 R9 zero divisor");
        pair(ONE, 64'h8000_0000_0000_0000, "R6 R9 negative zero divisor");
        pair(ONE, 64'h0000_0000_0000_0001, "R9 denormal divisor");
        pair(mk(2047, 52'h0), ONE, "R6 R9 infinite dividend");
        pair(ONE, mk(2047, 52'h0), "R6 R9 infinite divisor");
        pair(mk(2047, 52'h8), ONE, "R10 NaN dividend");
        pair(ONE, mk(2047, 52'h1), "R10 NaN divisor");
        apply({ONE, ONE}, {ONE, 64'h0}, 1'b1, 1'b1, "R5 lane 1 zero divisor");
        apply({ONE, mk(53, 52'h0)}, {ONE, ONE}, 1'b1, 1'b1, "R5 lane 1 dividend window");
        apply({mk(2047, 52'h3), ONE}, {ONE, 64'h1}, 1'b1, 1'b1, "R5 split lanes");
        apply({ONE, ONE}, {ONE, 64'h0}, 1'b0, 1'b1, "R3 disabled request");
        apply({ONE, ONE}, {64'h0, 64'h0}, 1'b0, 1'b0, "R4 idle with bad operands");

        for (int i = 0; i < 600; i++) begin
            logic [127:0] a, b;
            logic         en, v;
            a  = {rand_dbl(), rand_dbl()};
            b  = {rand_dbl(), rand_dbl()};
            en = ($urandom_range(0, 9) != 0);
            v  = ($urandom_range(0, 7) != 0);
            apply(a, b, en, v, "random R2 R3 R4 R6 R7 R8 R9");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule